// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Station Address Filter

This block turns a serial bit stream into the bytes of bit-oriented synchronous frames. Each incoming bit is presented on `bit_in` together with a one-cycle `bit_vld` strobe. The receiver looks for the flag pattern `01111110` to find where frames begin and end. It removes the zero bits that the transmitter inserted for transparency and recognises abort sequences. Each received byte appears on a one-cycle `rx_vld` pulse. The first byte of a frame carries `rx_sof`; the last carries `rx_eof`, together with the CRC verdict and the count of valid bits in that last byte.

The frame check sequence uses the 16-bit CCITT polynomial. Bits are processed least significant first, and the register can start from all ones or from all zeros. The two FCS bytes are passed through as ordinary data, so the consumer sees every bit that stood between the flags.

When station-address filtering is enabled, a frame is passed on only if its first byte equals the programmed address or the broadcast value. Any other frame is dropped before a single byte of it is delivered. A flag that closes one frame also opens the next one. Empty or sub-byte frames produce no output.

Top module: `hdlc_rx_filt`

## Requirements
- R1: After reset `st_hunt` is 1, and it stays 1 until the cycle after the last bit of a flag `01111110` is taken. While `st_hunt` is 1, `rx_vld` stays 0.
- R2: A 0 bit that follows five consecutive 1 bits is dropped. It goes neither into the delivered bytes nor into the CRC.
- R3: A seventh consecutive 1 bit aborts the frame in progress: no `rx_eof` is given for it, and `st_abort` and `st_hunt` both become 1 one cycle after that bit. `st_abort` returns to 0 one cycle after the next 0 bit, while `st_hunt` stays 1 until a flag.
- R4: With `addr_en` = 1, a frame is dropped without any `rx_vld` if its first complete byte differs from `addr`.
- R5: With `addr_en` = 1, a frame whose first byte is 0xFF is delivered whatever `addr` holds.
- R6: With `addr_en` = 0, every frame is delivered whatever its first byte is.
- R7: With `rx_eof`, `rx_resid` gives the number of valid bits in the final byte: 0 means all 8, and 1 to 7 mean a partial byte. The bits of a partial byte are right-aligned, with the earliest bit at bit 0 and zeros above. `rx_resid` is 0 when `rx_eof` is 0.
- R8: The CRC register is preset to 0xFFFF when `crc_preset_ones` = 1 and to 0x0000 when it is 0, and it is stepped on every kept bit with the reflected polynomial 0x8408. `rx_crc_err` is 1 with `rx_eof` exactly when the register is not 0xF0B8 at the closing flag. It is 0 at all other times.
- R9: A single flag between two frames closes the first frame and opens the second, and both frames are delivered completely.
- R10: A frame that holds fewer than 8 bits between its flags produces no `rx_vld` at all. Consecutive idle flags produce nothing either.
- R11: Bytes are assembled with the first received bit at bit 0. `rx_sof` marks the first delivered byte of a frame and `rx_eof` marks the last one. The FCS bytes are delivered as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new bit this cycle |
| addr_en | input | 1 | Enable station-address filtering |
| addr | input | 8 | Station address compared with the first byte |
| crc_preset_ones | input | 1 | 1: CRC preset all ones, 0: all zeros |
| rx_vld | output | 1 | A frame byte is on `rx_data` this cycle |
| rx_data | output | 8 | Frame byte |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last byte of a frame |
| rx_resid | output | 3 | Valid bits in the last byte (0 = 8) |
| rx_crc_err | output | 1 | CRC check failed (with `rx_eof`) |
| st_hunt | output | 1 | Searching for a flag |
| st_abort | output | 1 | Abort run in progress |

## Verification
The closing flag of one frame must do two things on the same edge: report that frame's end (its last byte, residue count and CRC verdict) and clear all state for the next frame. Frames that share one flag make these collide. The bench then checks that the first frame's final byte keeps its own `rx_eof` and CRC result, and that the second frame starts with `rx_sof` and ends cleanly. A partial final byte puts a held full byte and the residue byte on two consecutive cycles. Frames with residues of 1 and 4 bits check that both bytes appear in order with the correct flags.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int RES_W     = $clog2(BYTE_W);
    localparam int FLAG_ONES = 6;
    localparam int HOLD_D    = FLAG_ONES + 1;
    localparam int CRC_W     = 16;

    localparam logic [CRC_W-1:0]  CRC_POLY_R = 16'h8408;
    localparam logic [CRC_W-1:0]  CRC_GOOD   = 16'hF0B8;
    localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF;

    typedef enum logic {
        FS_HUNT = 1'b0,
        FS_OPEN = 1'b1
    } frm_state_e;

    // per-bit decode of the raw stream
    typedef struct packed {
        logic push;   // bit goes into the hold-back line
        logic val;    // value of that bit
        logic flag;   // flag just completed
        logic abrt;   // seventh one just seen
    } line_ev_t;

    // one output beat
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic [RES_W-1:0]  resid;
        logic              crc_err;
    } rx_beat_t;

    function automatic logic [CRC_W-1:0] crc_next(
        input logic [CRC_W-1:0] c,
        input logic             b,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = c[0] ^ b;
        crc_next = (c >> 1) ^ (fb ? poly : '0);
    endfunction

    // k bits collected at the top of acc moved down to bit 0
    function automatic logic [BYTE_W-1:0] right_align(
        input logic [BYTE_W-1:0] acc,
        input logic [RES_W-1:0]  k
    );
        logic [RES_W:0] sh;
        sh = (RES_W+1)'(BYTE_W) - {1'b0, k};
        right_align = acc >> sh;
    endfunction

endpackage

// File: rtl/hdlc_rx_destuff.sv
module hdlc_rx_destuff
    import hdlc_rx_pkg::*;
#(
    parameter int RUN_LIMIT = FLAG_ONES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_in,
    input  logic     bit_vld,
    output line_ev_t ev_o,
    output logic     abort_o
);
    localparam int CW = $clog2(RUN_LIMIT + 2);
    localparam logic [CW-1:0] RUN_FLAG  = CW'(RUN_LIMIT);
    localparam logic [CW-1:0] RUN_STUFF = CW'(RUN_LIMIT - 1);
    localparam logic [CW-1:0] RUN_SAT   = CW'(RUN_LIMIT + 1);

    logic [CW-1:0] run_q;

    always_comb begin
        ev_o.val  = bit_in;
        ev_o.flag = bit_vld && !bit_in && (run_q == RUN_FLAG);
        ev_o.abrt = bit_vld &&  bit_in && (run_q == RUN_FLAG);
        if (bit_in)
            ev_o.push = bit_vld && (run_q < RUN_FLAG);
        else
            ev_o.push = bit_vld && (run_q < RUN_STUFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            abort_o <= 1'b0;
        end else if (bit_vld) begin
            if (bit_in)
                run_q <= (run_q == RUN_SAT) ? RUN_SAT : run_q + 1'b1;
            else
                run_q <= '0;
            if (ev_o.abrt)
                abort_o <= 1'b1;
            else if (!bit_in)
                abort_o <= 1'b0;
        end
    end

endmodule

// File: rtl/hdlc_rx_holdback.sv
module hdlc_rx_holdback #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  logic val_i,
    input  logic flush_i,
    output logic commit_o,
    output logic cbit_o
);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    logic [DEPTH-1:0] line_q;
    logic [FW-1:0]    fill_q;
    logic             full;

    assign full     = (fill_q == FULL);
    assign commit_o = push_i && full && !flush_i;
    assign cbit_o   = line_q[DEPTH-1];

    // one stage per held bit
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || flush_i)
                line_q[g] <= 1'b0;
            else if (push_i)
                line_q[g] <= (g == 0) ? val_i : line_q[(g == 0) ? 0 : g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i)
            fill_q <= '0;
        else if (push_i && !full)
            fill_q <= fill_q + 1'b1;
    end

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = CRC_POLY_R
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         preset_ones_i,
    input  logic         step_i,
    input  logic         din_i,
    output logic [W-1:0] crc_o
);
    always_ff @(posedge clk) begin
        if (rst)
            crc_o <= '1;
        else if (load_i)
            crc_o <= preset_ones_i ? '1 : '0;
        else if (step_i)
            crc_o <= crc_next(crc_o, din_i, POLY);
    end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int                BW           = BYTE_W,
    parameter int                RW           = RES_W,
    parameter int                CW           = CRC_W,
    parameter logic [CW-1:0]     GOOD         = CRC_GOOD,
    parameter logic [BW-1:0]     BCAST        = BCAST_ADDR,
    parameter bit                BCAST_ACCEPT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flag_i,
    input  logic          abort_i,
    input  logic          commit_i,
    input  logic          cbit_i,
    input  logic [CW-1:0] crc_i,
    input  logic          addr_en_i,
    input  logic [BW-1:0] addr_i,
    output logic          open_o,
    output rx_beat_t      beat_o,
    output logic          hunt_o
);
    localparam logic [RW-1:0] LAST_BIT = RW'(BW - 1);

    frm_state_e    st_q;
    logic [BW-1:0] acc_q;
    logic [RW-1:0] nbit_q;
    logic [BW-1:0] held_q;
    logic          held_vld_q;
    logic          held_sof_q;
    logic          first_q;
    rx_beat_t      tail_q;
    rx_beat_t      beat_q;

    logic [BW-1:0] acc_nxt;
    logic          bc_hit;
    logic          addr_ok;
    logic          crc_bad;

    assign acc_nxt = {cbit_i, acc_q[BW-1:1]};
    assign crc_bad = (crc_i != GOOD);

    if (BCAST_ACCEPT) begin : g_bcast
        assign bc_hit = (acc_nxt == BCAST);
    end else begin : g_nobcast
        assign bc_hit = 1'b0;
    end

    assign addr_ok = !addr_en_i || (acc_nxt == addr_i) || bc_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FS_HUNT;
            acc_q      <= '0;
            nbit_q     <= '0;
            held_q     <= '0;
            held_vld_q <= 1'b0;
            held_sof_q <= 1'b0;
            first_q    <= 1'b0;
            tail_q     <= '0;
            beat_q     <= '0;
        end else begin
            beat_q <= '0;
            if (tail_q.vld) begin
                beat_q <= tail_q;
                tail_q <= '0;
            end
            if (abort_i) begin
                st_q       <= FS_HUNT;
                held_vld_q <= 1'b0;
            end else if (flag_i) begin
                if (st_q == FS_OPEN && held_vld_q) begin
                    beat_q.vld  <= 1'b1;
                    beat_q.data <= held_q;
                    beat_q.sof  <= held_sof_q;
                    if (nbit_q == '0) begin
                        beat_q.eof     <= 1'b1;
                        beat_q.crc_err <= crc_bad;
                    end else begin
                        tail_q.vld     <= 1'b1;
                        tail_q.data    <= right_align(acc_q, nbit_q);
                        tail_q.sof     <= 1'b0;
                        tail_q.eof     <= 1'b1;
                        tail_q.resid   <= nbit_q;
                        tail_q.crc_err <= crc_bad;
                    end
                end
                st_q       <= FS_OPEN;
                held_vld_q <= 1'b0;
                held_sof_q <= 1'b0;
                acc_q      <= '0;
                nbit_q     <= '0;
                first_q    <= 1'b1;
            end else if (commit_i && st_q == FS_OPEN) begin
                if (nbit_q == LAST_BIT) begin
                    acc_q  <= '0;
                    nbit_q <= '0;
                    if (first_q) begin
                        first_q <= 1'b0;
                        if (addr_ok) begin
                            held_q     <= acc_nxt;
                            held_vld_q <= 1'b1;
                            held_sof_q <= 1'b1;
                        end else begin
                            st_q <= FS_HUNT;
                        end
                    end else begin
                        beat_q.vld  <= 1'b1;
                        beat_q.data <= held_q;
                        beat_q.sof  <= held_sof_q;
                        held_q      <= acc_nxt;
                        held_sof_q  <= 1'b0;
                    end
                end else begin
                    acc_q  <= acc_nxt;
                    nbit_q <= nbit_q + 1'b1;
                end
            end
        end
    end

    assign open_o = (st_q == FS_OPEN);
    assign hunt_o = (st_q == FS_HUNT);
    assign beat_o = beat_q;

endmodule

// File: rtl/hdlc_rx_filt.sv
module hdlc_rx_filt
    import hdlc_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0]  POLY         = CRC_POLY_R,
    parameter logic [CRC_W-1:0]  GOOD         = CRC_GOOD,
    parameter logic [BYTE_W-1:0] BCAST        = BCAST_ADDR,
    parameter bit                BCAST_ACCEPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              addr_en,
    input  logic [BYTE_W-1:0] addr,
    input  logic              crc_preset_ones,
    output logic              rx_vld,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_sof,
    output logic              rx_eof,
    output logic [RES_W-1:0]  rx_resid,
    output logic              rx_crc_err,
    output logic              st_hunt,
    output logic              st_abort
);
    line_ev_t         ev;
    logic             commit;
    logic             cbit;
    logic             frm_open;
    logic [CRC_W-1:0] crc;
    rx_beat_t         beat;

    hdlc_rx_destuff #(.RUN_LIMIT(FLAG_ONES)) u_destuff (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .ev_o    (ev),
        .abort_o (st_abort)
    );

    hdlc_rx_holdback #(.DEPTH(HOLD_D)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .push_i   (ev.push),
        .val_i    (ev.val),
        .flush_i  (ev.flag || ev.abrt),
        .commit_o (commit),
        .cbit_o   (cbit)
    );

    hdlc_rx_crc #(.W(CRC_W), .POLY(POLY)) u_crc (
        .clk           (clk),
        .rst           (rst),
        .load_i        (ev.flag),
        .preset_ones_i (crc_preset_ones),
        .step_i        (commit && frm_open),
        .din_i         (cbit),
        .crc_o         (crc)
    );

    hdlc_rx_framer #(
        .BW           (BYTE_W),
        .RW           (RES_W),
        .CW           (CRC_W),
        .GOOD         (GOOD),
        .BCAST        (BCAST),
        .BCAST_ACCEPT (BCAST_ACCEPT)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .flag_i    (ev.flag),
        .abort_i   (ev.abrt),
        .commit_i  (commit),
        .cbit_i    (cbit),
        .crc_i     (crc),
        .addr_en_i (addr_en),
        .addr_i    (addr),
        .open_o    (frm_open),
        .beat_o    (beat),
        .hunt_o    (st_hunt)
    );

    assign rx_vld     = beat.vld;
    assign rx_data    = beat.data;
    assign rx_sof     = beat.sof;
    assign rx_eof     = beat.eof;
    assign rx_resid   = beat.resid;
    assign rx_crc_err = beat.crc_err;

endmodule

// File: rtl/hdlc_rx_filt_chk.sv
module hdlc_rx_filt_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_in,
    input logic       bit_vld,
    input logic       rx_vld,
    input logic       rx_eof,
    input logic [2:0] rx_resid,
    input logic       rx_crc_err,
    input logic       st_hunt,
    input logic       st_abort
);
    // R1
    no_out_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        rx_vld |-> !st_hunt);

    // R3
    abort_in_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        st_abort |-> st_hunt);

    // R3
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_abort) |-> $past(bit_vld && bit_in));

    // R3
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_abort) |-> $past(bit_vld && !bit_in));

    // R7
    resid_only_eof_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_resid != 3'd0) |-> rx_eof);

    // R8
    crc_err_with_eof_chk: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |-> rx_eof);

    // R11
    eof_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_eof |-> rx_vld);

endmodule

bind hdlc_rx_filt hdlc_rx_filt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_in     (bit_in),
    .bit_vld    (bit_vld),
    .rx_vld     (rx_vld),
    .rx_eof     (rx_eof),
    .rx_resid   (rx_resid),
    .rx_crc_err (rx_crc_err),
    .st_hunt    (st_hunt),
    .st_abort   (st_abort)
);

// File: tb/sim_hdlc_rx_filt.sv
module sim_hdlc_rx_filt;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       addr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       crc_preset_ones = 1'b1;
    logic       rx_vld, rx_sof, rx_eof, rx_crc_err, st_hunt, st_abort;
    logic [7:0] rx_data;
    logic [2:0] rx_resid;

    always #2.5 clk = ~clk;

    hdlc_rx_filt u0 (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .addr_en(addr_en), .addr(addr), .crc_preset_ones(crc_preset_ones),
        .rx_vld(rx_vld), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_resid(rx_resid), .rx_crc_err(rx_crc_err),
        .st_hunt(st_hunt), .st_abort(st_abort)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int txo = 0;

    // capture of delivered beats
    int         cap_n = 0;
    logic [7:0] cap_d [0:31];
    logic [5:0] cap_f [0:31];   // {sof, eof, resid, err}

    always @(negedge clk) begin
        if (!rst && rx_vld && cap_n < 32) begin
            cap_d[cap_n] = rx_data;
            cap_f[cap_n] = {rx_sof, rx_eof, rx_resid, rx_crc_err};
            cap_n++;
        end
    end

    typedef struct packed {
        logic [31:0] data;
        logic [5:0]  nbits;
        logic        aen;
        logic [7:0]  adr;
        logic        ones;
        logic        bad;
        logic        acc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [0:NV-1] = '{
        '{32'h007EFF12, 6'd24, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
        '{32'h00C35A21, 6'd24, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},
        '{32'h44332211, 6'd32, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{32'h000BCDEF, 6'd20, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
        '{32'h00009942, 6'd16, 1'b1, 8'h42, 1'b1, 1'b0, 1'b1},
        '{32'h00009917, 6'd16, 1'b1, 8'h42, 1'b1, 1'b0, 1'b0},
        '{32'h000099FF, 6'd16, 1'b1, 8'h42, 1'b1, 1'b0, 1'b1},
        '{32'h00009917, 6'd16, 1'b0, 8'h42, 1'b1, 1'b0, 1'b1},
        '{32'h0001F0F0, 6'd17, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R2 R11 stuffing";
            1: return "R8 bad fcs";
            2: return "R8 zero preset";
            3: return "R7 residue 4";
            4: return "R4 address hit";
            5: return "R4 address miss";
            6: return "R5 broadcast";
            7: return "R6 filter off";
            default: return "R7 R8 residue 1 bad";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tx_raw(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic tx_data(input logic b);
        tx_raw(b);
        if (b) begin
            txo++;
            if (txo == 5) begin
                tx_raw(1'b0);
                txo = 0;
            end
        end else begin
            txo = 0;
        end
    endtask

    task automatic tx_flag();
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        txo = 0;
    endtask

    function automatic logic [15:0] crc_of(input logic [31:0] d, input int nb,
                                           input logic ones);
        logic [15:0] c;
        c = ones ? 16'hFFFF : 16'h0000;
        for (int j = 0; j < nb; j++)
            c = (c >> 1) ^ ((c[0] ^ d[j]) ? 16'h8408 : 16'h0000);
        return c;
    endfunction

    // payload plus FCS, with stuffing; returns the full bit image
    task automatic send_body(input logic [31:0] d, input int nb, input logic ones,
                             input logic bad, output logic [63:0] img);
        logic [15:0] fcs;
        fcs = ~crc_of(d, nb, ones);
        if (bad) fcs[0] = ~fcs[0];
        img = 64'd0;
        for (int j = 0; j < nb; j++) img[j] = d[j];
        for (int j = 0; j < 16; j++) img[nb + j] = fcs[j];
        for (int j = 0; j < nb + 16; j++) tx_data(img[j]);
    endtask

    // compare captured beats starting at base against a frame image
    task automatic cmp_frame(input logic [63:0] img, input int nb, input logic bad,
                             input int base, input string tag);
        int tot, nfull, r, ne;
        logic [7:0] eb;
        logic [5:0] ef;
        tot   = nb + 16;
        nfull = tot / 8;
        r     = tot % 8;
        ne    = nfull + ((r != 0) ? 1 : 0);
        for (int k = 0; k < ne; k++) begin
            if (k < nfull) eb = img[8*k +: 8];
            else           eb = 8'((img >> (8*nfull)) & ((64'd1 << r) - 1));
            ef = {(k == 0), (k == ne-1), (k == ne-1) ? 3'(r) : 3'd0,
                  (k == ne-1) ? bad : 1'b0};
            check({cap_d[base+k], cap_f[base+k]} == {eb, ef}, tag,
                  {18'd0, cap_d[base+k], cap_f[base+k]}, {18'd0, eb, ef});
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        logic [63:0] img;
        int tot, ne;
        v = VT[i];
        addr_en = v.aen;
        addr = v.adr;
        crc_preset_ones = v.ones;
        cap_n = 0;
        tx_flag();
        send_body(v.data, int'(v.nbits), v.ones, v.bad, img);
        tx_flag();
        repeat (4) @(negedge clk);
        tot = int'(v.nbits) + 16;
        ne = v.acc ? (tot / 8 + ((tot % 8 != 0) ? 1 : 0)) : 0;
        check(cap_n == ne, vtag(i), cap_n, ne);
        if (v.acc && cap_n == ne) cmp_frame(img, int'(v.nbits), v.bad, 0, vtag(i));
        check(st_hunt == 1'b0, vtag(i), {31'd0, st_hunt}, 32'd0);
    endtask

    initial begin : main
        logic [63:0] ia, ib;
        int eofs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(st_hunt == 1'b1 && st_abort == 1'b0 && rx_vld == 1'b0,
              "R1 reset state", {29'd0, st_hunt, st_abort, rx_vld}, 32'h4);

        // R1: bits without a flag keep hunting, no output
        for (int i = 0; i < 40; i++) tx_raw(i[0] ^ i[2]);
        check(st_hunt == 1'b1 && cap_n == 0, "R1 hunt without flag",
              {31'd0, st_hunt}, 32'd1);
        tx_flag();
        check(st_hunt == 1'b0, "R1 flag leaves hunt", {31'd0, st_hunt}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: back-to-back frames sharing one flag
        addr_en = 1'b0;
        crc_preset_ones = 1'b1;
        cap_n = 0;
        tx_flag();
        send_body(32'h00004321, 16, 1'b1, 1'b0, ia);
        tx_flag();
        send_body(32'h00000065, 8, 1'b1, 1'b0, ib);
        tx_flag();
        repeat (4) @(negedge clk);
        check(cap_n == 7, "R9 shared flag count", cap_n, 7);
        if (cap_n == 7) begin
            cmp_frame(ia, 16, 1'b0, 0, "R9 first frame");
            cmp_frame(ib, 8, 1'b0, 4, "R9 second frame");
        end

        // R10: sub-byte frame and idle flags
        cap_n = 0;
        tx_flag();
        for (int i = 0; i < 5; i++) tx_data(i[0]);
        tx_flag();
        tx_flag();
        tx_flag();
        repeat (4) @(negedge clk);
        check(cap_n == 0, "R10 short frame and idle flags", cap_n, 0);
        check(st_hunt == 1'b0, "R10 still framing", {31'd0, st_hunt}, 32'd0);

        // R3: abort in the middle of a frame
        cap_n = 0;
        tx_flag();
        for (int i = 0; i < 16; i++) tx_data(i[0] ^ i[3]);
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        check(st_abort == 1'b0, "R3 six ones no abort", {31'd0, st_abort}, 32'd0);
        tx_raw(1'b1);
        check(st_abort == 1'b1 && st_hunt == 1'b1, "R3 seventh one aborts",
              {30'd0, st_abort, st_hunt}, 32'h3);
        for (int i = 0; i < 3; i++) tx_raw(1'b1);
        check(st_abort == 1'b1, "R3 abort held during run", {31'd0, st_abort}, 32'd1);
        tx_raw(1'b0);
        check(st_abort == 1'b0 && st_hunt == 1'b1, "R3 abort ends on zero",
              {30'd0, st_abort, st_hunt}, 32'h1);
        eofs = 0;
        for (int k = 0; k < cap_n; k++) if (cap_f[k][4]) eofs++;
        check(eofs == 0, "R3 no eof for aborted frame", eofs, 0);
        tx_flag();
        check(st_hunt == 1'b0, "R3 flag after abort", {31'd0, st_hunt}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule